// File: doc/BRIEF.md
# Supervisor Counter-Inhibit Alias Register

This block holds the machine-level counter-inhibit bits and gives supervisor code a restricted window onto them through one 32-bit control register. Each implemented bit, while set, freezes one counter: bit 0 freezes the cycle counter, bit 2 freezes the retired-instruction counter, and bits 3 to 31 freeze hardware performance counters 3 to 31. The per-bit inhibit signals leave the block directly from the storage flops and go to the counter logic.

A write through the supervisor view updates the same-numbered machine-level bits. A bit whose counter is not implemented, as set by a per-bit parameter, stays zero. A read returns the stored bits ANDed with the supervisor counter-enable delegation mask, with bit 1 cleared. Access legality depends on the environment-config delegation-enable bit and on the current privilege mode, including the virtualized modes. A faulting access raises either an illegal-instruction flag or a virtual-instruction flag. Read data and both flags are registered and appear one cycle after the request.

Top module: `sup_cntinh_csr`

## Requirements
- R1: Only an access with `csr_addr` equal to `REG_ADDR` (default 0x120) is decoded. Any other address changes no state, raises no flag and returns read data 0.
- R2: `cnt_inhibit[k]` holds the stored inhibit bit k: bit 0 for the cycle counter, bit 2 for the retired-instruction counter, and bits 3..31 for performance counters 3..31.
- R3: A legal write updates `cnt_inhibit` at the clock edge that samples it. When no legal write is sampled, `cnt_inhibit` keeps its value.
- R4: A bit whose `IMPL_MASK` bit is 0 resets to 0, reads 0 and ignores writes.
- R5: Bit 1 is reserved. It is 0 in `cnt_inhibit` and in read data whatever is written.
- R6: One cycle after a legal read, `csr_rdata` equals the stored bits AND `deleg_mask`, with bit 1 cleared. When both read and write are requested in the same cycle, the value before the write is returned.
- R7: Privilege is encoded as U=3'b000, S=3'b001, M=3'b011, VU=3'b100, VS=3'b101. An access with `cfg_deleg_en`=0 from M raises `illegal_trap` one cycle later.
- R8: An access with `cfg_deleg_en`=1 from VS or VU raises `virtual_trap` one cycle later. At most one flag is ever set.
- R9: A faulting access leaves `cnt_inhibit` unchanged, and its read data is 0.
- R10: After reset, `csr_rdata`, `illegal_trap` and `virtual_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_rd | input | 1 | Read request |
| csr_wr | input | 1 | Write request |
| csr_wdata | input | 32 | Write data |
| priv_mode | input | 3 | Current privilege mode (encoding in R7) |
| cfg_deleg_en | input | 1 | Environment-config delegation-enable bit |
| deleg_mask | input | 32 | Supervisor counter-enable delegation mask |
| csr_rdata | output | 32 | Registered read data |
| illegal_trap | output | 1 | Registered illegal-instruction flag |
| virtual_trap | output | 1 | Registered virtual-instruction flag |
| cnt_inhibit | output | 32 | Per-counter inhibit signals |

## Verification
A single 1 is walked through all 32 bit positions and read back with a full mask. This separates implemented bits, unimplemented bits and the reserved bit 1, and shows that each write lands on its own output bit. The stored value is then all ones and is read with zero, alternating and walking-one masks, which shows that the mask and the stored value are ANDed and not merely gated. Every privilege code is then combined with both delegation-enable values and with read-only, write-only and read-write requests. The write data is always the complement of the stored value, so a fault that let a write through would show up as a change. Finally, accesses to neighbouring addresses show that the decode matches only the exact register address.

// File: rtl/sci_pkg.sv
package sci_pkg;
  typedef enum logic [2:0] {
    PRV_U  = 3'b000,
    PRV_S  = 3'b001,
    PRV_M  = 3'b011,
    PRV_VU = 3'b100,
    PRV_VS = 3'b101
  } prv_e;

  typedef struct packed {
    logic hit;
    logic rd_ok;
    logic wr_ok;
    logic ill;
    logic virt;
  } acc_s;
endpackage

// File: rtl/sci_decode.sv
module sci_decode
  import sci_pkg::*;
#(
  parameter int          AW       = 12,
  parameter logic [AW-1:0] REG_ADDR = 12'h120
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [2:0]    priv,
  input  logic          deleg_en,
  output acc_s          acc
);
  logic is_m, is_virt;

  always_comb begin
    is_m     = (priv == PRV_M);
    is_virt  = (priv == PRV_VS) || (priv == PRV_VU);
    acc.hit  = (rd || wr) && (addr == REG_ADDR);
    acc.ill  = acc.hit && !deleg_en && is_m;
    acc.virt = acc.hit && deleg_en && is_virt;
    acc.rd_ok = acc.hit && rd && !acc.ill && !acc.virt;
    acc.wr_ok = acc.hit && wr && !acc.ill && !acc.virt;
  end
endmodule

// File: rtl/sci_store.sv
module sci_store #(
  parameter int           W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] bits
);
  localparam logic [W-1:0] RSVD = W'(2);
  localparam logic [W-1:0] LIVE = IMPL_MASK & ~RSVD;

  always_ff @(posedge clk) begin
    if (rst)        bits <= '0;
    else if (wr_en) bits <= wdata & LIVE;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bits));
  p_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
    bits[1] == 1'b0);
endmodule

// File: rtl/sci_rview.sv
module sci_rview
  import sci_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  acc_s         acc,
  input  logic [W-1:0] bits,
  input  logic [W-1:0] mask,
  output logic [W-1:0] rdata,
  output logic         ill_q,
  output logic         virt_q
);
  localparam logic [W-1:0] RSVD = W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      ill_q  <= 1'b0;
      virt_q <= 1'b0;
    end else begin
      rdata  <= acc.rd_ok ? (bits & mask & ~RSVD) : '0;
      ill_q  <= acc.ill;
      virt_q <= acc.virt;
    end
  end

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(ill_q && virt_q));
  p_fault_rdata_r9: assert property (@(posedge clk) disable iff (rst)
    (ill_q || virt_q) |-> (rdata == '0));
  p_mask_bound_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rdata & ~$past(mask)) == '0) && (rdata[1] == 1'b0));
endmodule

// File: rtl/sup_cntinh_csr.sv
module sup_cntinh_csr
  import sci_pkg::*;
#(
  parameter int             W         = 32,
  parameter int             AW        = 12,
  parameter logic [AW-1:0]  REG_ADDR  = 12'h120,
  parameter logic [W-1:0]   IMPL_MASK = 32'hF0F0_F0F5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] csr_addr,
  input  logic          csr_rd,
  input  logic          csr_wr,
  input  logic [W-1:0]  csr_wdata,
  input  logic [2:0]    priv_mode,
  input  logic          cfg_deleg_en,
  input  logic [W-1:0]  deleg_mask,
  output logic [W-1:0]  csr_rdata,
  output logic          illegal_trap,
  output logic          virtual_trap,
  output logic [W-1:0]  cnt_inhibit
);
  acc_s acc;

  sci_decode #(.AW(AW), .REG_ADDR(REG_ADDR)) u_dec (
    .addr(csr_addr), .rd(csr_rd), .wr(csr_wr), .priv(priv_mode),
    .deleg_en(cfg_deleg_en), .acc(acc)
  );

  sci_store #(.W(W), .IMPL_MASK(IMPL_MASK)) u_store (
    .clk(clk), .rst(rst), .wr_en(acc.wr_ok), .wdata(csr_wdata),
    .bits(cnt_inhibit)
  );

  sci_rview #(.W(W)) u_rview (
    .clk(clk), .rst(rst), .acc(acc), .bits(cnt_inhibit), .mask(deleg_mask),
    .rdata(csr_rdata), .ill_q(illegal_trap), .virt_q(virtual_trap)
  );

  p_fault_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (acc.ill || acc.virt) |=> $stable(cnt_inhibit));
  p_foreign_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (csr_addr != REG_ADDR) |=> $stable(cnt_inhibit) && !illegal_trap && !virtual_trap);
endmodule

// File: tb/sup_cntinh_csr_bench.sv
`timescale 1ns/1ps
module sup_cntinh_csr_bench;
  localparam logic [31:0] IMPL = 32'hF0F0_F0F5;
  localparam logic [11:0] RA   = 12'h120;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] csr_addr;
  logic        csr_rd, csr_wr;
  logic [31:0] csr_wdata;
  logic [2:0]  priv_mode;
  logic        cfg_deleg_en;
  logic [31:0] deleg_mask;
  logic [31:0] csr_rdata;
  logic        illegal_trap, virtual_trap;
  logic [31:0] cnt_inhibit;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_exp;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sup_cntinh_csr #(.IMPL_MASK(IMPL)) u_sup_cntinh_csr (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .priv_mode(priv_mode), .cfg_deleg_en(cfg_deleg_en),
    .deleg_mask(deleg_mask), .csr_rdata(csr_rdata), .illegal_trap(illegal_trap),
    .virtual_trap(virtual_trap), .cnt_inhibit(cnt_inhibit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input string ctx, input logic [11:0] a, input bit r, input bit w,
                    input logic [31:0] d, input logic [2:0] p, input bit de,
                    input logic [31:0] mk);
    bit hit, eill, evirt, ok;
    logic [31:0] erd, enext;
    @(negedge clk);
    csr_addr = a; csr_rd = r; csr_wr = w; csr_wdata = d;
    priv_mode = p; cfg_deleg_en = de; deleg_mask = mk;
    hit   = (r || w) && (a == RA);
    eill  = hit && !de && (p == 3'b011);
    evirt = hit && de && (p == 3'b101 || p == 3'b100);
    ok    = hit && !eill && !evirt;
    erd   = (ok && r) ? (m_exp & mk & ~32'h2) : 32'h0;
    enext = (ok && w) ? (d & IMPL & ~32'h2) : m_exp;
    @(negedge clk);
    chk({ctx, " R6/R9 rdata"}, csr_rdata, erd);
    chk({ctx, " R7 illegal"}, {31'h0, illegal_trap}, {31'h0, eill});
    chk({ctx, " R8 virtual"}, {31'h0, virtual_trap}, {31'h0, evirt});
    chk({ctx, " R3 inhibit"}, cnt_inhibit, enext);
    chk({ctx, " R4 unimplemented zero"}, cnt_inhibit & ~IMPL, 32'h0);
    chk({ctx, " R5 reserved bit"}, {31'h0, cnt_inhibit[1]}, 32'h0);
    m_exp = enext;
    csr_rd = 1'b0; csr_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] prv [5];
    prv[0] = 3'b000; prv[1] = 3'b001; prv[2] = 3'b011; prv[3] = 3'b100; prv[4] = 3'b101;
    rst = 1'b1; csr_addr = '0; csr_rd = 0; csr_wr = 0; csr_wdata = '0;
    priv_mode = 3'b001; cfg_deleg_en = 1'b1; deleg_mask = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset rdata", csr_rdata, 32'h0);
    chk("R10 reset illegal", {31'h0, illegal_trap}, 32'h0);
    chk("R10 reset virtual", {31'h0, virtual_trap}, 32'h0);
    chk("R4 reset unimplemented", cnt_inhibit & ~IMPL, 32'h0);
    // Implemented bits have no defined reset value: start the model by writing.
    m_exp = cnt_inhibit;
    op("init", RA, 0, 1, 32'h0, 3'b001, 1, '1);

    // Walking one through every bit position.
    for (int k = 0; k < 32; k++) begin
      op("walk wr", RA, 0, 1, 32'h1 << k, 3'b001, 1, '1);
      chk("R2 bit mapping", {31'h0, cnt_inhibit[k]}, {31'h0, (k != 1) && IMPL[k]});
      op("walk rd", RA, 1, 0, 32'h0, 3'b001, 1, '1);
    end

    // Mask patterns against an all-ones store.
    op("fill", RA, 0, 1, '1, 3'b001, 1, '1);
    op("mask zero", RA, 1, 0, '0, 3'b001, 1, 32'h0);
    op("mask ones", RA, 1, 0, '0, 3'b001, 1, 32'hFFFF_FFFF);
    op("mask alt A", RA, 1, 0, '0, 3'b001, 1, 32'hAAAA_AAAA);
    op("mask alt 5", RA, 1, 0, '0, 3'b001, 1, 32'h5555_5555);
    for (int k = 0; k < 32; k++)
      op("mask walk", RA, 1, 0, '0, 3'b000, 0, 32'h1 << k);

    // Privilege x delegation-enable x request-kind sweep.
    for (int de = 0; de < 2; de++)
      for (int pi = 0; pi < 5; pi++)
        for (int rw = 1; rw < 4; rw++)
          op("priv sweep", RA, rw[0], rw[1], ~m_exp, prv[pi], de[0], 32'hFFFF_FFFF);

    // Foreign addresses.
    op("R1 foreign addr", 12'h121, 1, 1, ~m_exp, 3'b001, 1, '1);
    op("R1 foreign addr", 12'h320, 1, 1, ~m_exp, 3'b011, 0, '1);
    op("R1 foreign addr", 12'h020, 1, 1, ~m_exp, 3'b101, 1, '1);
    op("R1 exact addr", RA, 1, 1, 32'h1234_5678, 3'b001, 1, '1);
    op("R1 readback", RA, 1, 0, 32'h0, 3'b001, 1, '1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule